// File: doc/BRIEF.md
# Dual-Speed I2C Clock Phase Generator

This block times the clock line of an I2C master. Four count inputs are supplied: a high and a low period for standard speed, and a high and a low period for fast speed. A two-bit speed code picks the pair in use. The block runs only while its enable input is 1. It copies the counts and the speed code only while the enable is 0, so software reprograms it between transfers. Counts are in cycles of the block clock. A value is normally (clock in kHz × period in tenths of a µs / 10000) + 1. The bus floor is 4.0 µs high and 4.7 µs low at standard speed, and 0.6 µs high and 1.3 µs low at fast speed.

A bus engine asks for a run of clock pulses with a start request and ends it with a stop request. The block drives an open-drain enable for the line. A 1 pulls the line low and a 0 releases it. A one-cycle tick marks every change of that enable. After each release the block reads the line back through a synchronizer. The high count starts only once the line is seen high, so a device holding the line low stretches the clock. A finished stop leaves the line released and raises the idle flag.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, idle is 1, scl_oe is 0 and phase_tick is 0.
- R2: A start request seen while idle with run_en at 1 drives scl_oe to 1 from the next cycle for exactly L cycles, where L is the selected low count.
- R3: After each low phase, scl_oe stays 0 for exactly H + 3 cycles when no device holds the line. H is the selected high count, and the extra 3 cycles are the two synchronizer stages plus the cycle that detects the line high. A new low phase then follows.
- R4: Speed code 2'b10 selects the fast high and low counts. Codes 2'b01, 2'b00 and 2'b11 select the standard counts.
- R5: A count below 6 is treated as 6.
- R6: If a device holds the line low for S extra cycles after scl_oe falls, that released phase lasts H + 3 + S cycles.
- R7: A stop request while active is held until the end of the current or next high phase. The block then goes idle (idle = 1, scl_oe = 0) and drives no further low phase. A stop request in the last cycle of a high phase is honoured in that same cycle.
- R8: Changes to any count or to the speed code while run_en is 1 have no effect on the phases.
- R9: Clearing run_en returns the block to idle with scl_oe at 0 in the next cycle.
- R10: phase_tick is 1 for exactly the cycles in which scl_oe differs from its value in the previous cycle.
- R11: A start request is ignored while run_en is 0 or while a run is active. A stop request is ignored while idle.

Top module ports (in port-list order):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enable; configuration is copied only while 0 |
| spd_mode | input | 2 | Speed code: 2'b10 fast, otherwise standard |
| std_high_cnt | input | CNT_W | Standard-speed high count |
| std_low_cnt | input | CNT_W | Standard-speed low count |
| fast_high_cnt | input | CNT_W | Fast-speed high count |
| fast_low_cnt | input | CNT_W | Fast-speed low count |
| start_req | input | 1 | Begin clocking (one-cycle pulse) |
| stop_req | input | 1 | End clocking after a high phase (one-cycle pulse) |
| scl_in | input | 1 | Line level as read back from the pad |
| scl_oe | output | 1 | 1 pulls the line low |
| phase_tick | output | 1 | One-cycle pulse on every change of scl_oe |
| idle | output | 1 | 1 while no run is active |

## Verification
A stop request can arrive in the very cycle that a high phase expires. In that cycle the block must either finish the run or start another low phase. The bench counts released cycles from the observed fall of scl_oe and asserts stop_req exactly in the final cycle of the last high phase, once alongside a stretched phase. The scoreboard then requires that this high phase ends with idle rising and that no further low phase appears. A stop one cycle late would instead show an unexpected low phase.

// File: rtl/i2c_sclg_pkg.sv
package i2c_sclg_pkg;

  localparam logic [1:0] SPD_STD  = 2'b01;
  localparam logic [1:0] SPD_FAST = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LOW     = 2'd1,
    PH_RELEASE = 2'd2,
    PH_HIGH    = 2'd3
  } phase_e;

  // Raise a count to the floor value.
  function automatic int unsigned at_least(int unsigned v, int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // Only the fast code selects the fast pair; every other code runs standard.
  function automatic logic is_fast(logic [1:0] code);
    return code == SPD_FAST;
  endfunction

endpackage

// File: rtl/i2c_sclg_cfg.sv
module i2c_sclg_cfg
  import i2c_sclg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       spd_mode,
  input  logic [CNT_W-1:0] std_high_cnt,
  input  logic [CNT_W-1:0] std_low_cnt,
  input  logic [CNT_W-1:0] fast_high_cnt,
  input  logic [CNT_W-1:0] fast_low_cnt,
  output logic [CNT_W-1:0] hi_len,
  output logic [CNT_W-1:0] lo_len
);
  localparam int NREG = 4;
  localparam int I_SH = 0, I_SL = 1, I_FH = 2, I_FL = 3;

  logic [CNT_W-1:0] raw  [NREG];
  logic [CNT_W-1:0] held [NREG];
  logic             fast_q;

  assign raw[I_SH] = std_high_cnt;
  assign raw[I_SL] = std_low_cnt;
  assign raw[I_FH] = fast_high_cnt;
  assign raw[I_FL] = fast_low_cnt;

  for (genvar i = 0; i < NREG; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held[i] <= CNT_W'(MIN_CNT);
      else if (!run_en) held[i] <= CNT_W'(at_least(32'(raw[i]), MIN_CNT));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fast_q <= 1'b0;
    else if (!run_en) fast_q <= is_fast(spd_mode);
  end

  assign hi_len = fast_q ? held[I_FH] : held[I_SH];
  assign lo_len = fast_q ? held[I_FL] : held[I_SL];

  // R8: configuration frozen while running
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(hi_len) && $stable(lo_len)));
  // R5: selected counts never below floor
  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len >= CNT_W'(MIN_CNT)) && (lo_len >= CNT_W'(MIN_CNT)));

endmodule

// File: rtl/i2c_sclg_sync.sv
module i2c_sclg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= d;
    end
  end else begin : g_many
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_sclg_phase.sv
module i2c_sclg_phase
  import i2c_sclg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             line_hi,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output logic             scl_oe,
  output logic             phase_tick,
  output logic             idle
);
  phase_e           state, nstate;
  logic [CNT_W-1:0] cnt;
  logic             stop_pend;

  // named events
  logic go, low_done, high_done, stop_now, enter_low, enter_high;
  assign go         = (state == PH_IDLE) && run_en && start_req;
  assign low_done   = (state == PH_LOW)  && (cnt == '0);
  assign high_done  = (state == PH_HIGH) && (cnt == '0);
  assign stop_now   = stop_pend || stop_req;
  assign enter_low  = (nstate == PH_LOW)  && (state != PH_LOW);
  assign enter_high = (nstate == PH_HIGH) && (state != PH_HIGH);

  always_comb begin
    nstate = state;
    if (!run_en) nstate = PH_IDLE;
    else begin
      unique case (state)
        PH_IDLE:    if (go)        nstate = PH_LOW;
        PH_LOW:     if (low_done)  nstate = PH_RELEASE;
        PH_RELEASE: if (line_hi)   nstate = PH_HIGH;
        PH_HIGH:    if (high_done) nstate = stop_now ? PH_IDLE : PH_LOW;
        default:                   nstate = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      stop_pend  <= 1'b0;
      phase_tick <= 1'b0;
    end else begin
      state      <= nstate;
      phase_tick <= (nstate == PH_LOW) != (state == PH_LOW);
      if (enter_low)       cnt <= lo_len - 1'b1;
      else if (enter_high) cnt <= hi_len - 1'b1;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      if (nstate == PH_IDLE)                    stop_pend <= 1'b0;
      else if (stop_req && state != PH_IDLE)    stop_pend <= 1'b1;
    end
  end

  assign scl_oe = (state == PH_LOW);
  assign idle   = (state == PH_IDLE);

  // R9: enable low forces idle
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> idle);
  // R6: no high count while the line is still held low
  a_r6_wait_line: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_RELEASE && !line_hi && run_en) |=> (state == PH_RELEASE));
  // R7: stop at high expiry ends the run
  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (high_done && stop_now && run_en) |=> (idle && !scl_oe));
  // R10: tick only on a line-enable change
  a_r10_tick_edge: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> (scl_oe != $past(scl_oe)));
  // R11: start while active does not restart the low count
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HIGH && !high_done && run_en) |=> (state == PH_HIGH));

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_sclg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_CNT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       spd_mode,
  input  logic [CNT_W-1:0] std_high_cnt,
  input  logic [CNT_W-1:0] std_low_cnt,
  input  logic [CNT_W-1:0] fast_high_cnt,
  input  logic [CNT_W-1:0] fast_low_cnt,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             phase_tick,
  output logic             idle
);
  logic [CNT_W-1:0] hi_len, lo_len;
  logic             line_hi;

  i2c_sclg_cfg #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .spd_mode(spd_mode),
    .std_high_cnt(std_high_cnt), .std_low_cnt(std_low_cnt),
    .fast_high_cnt(fast_high_cnt), .fast_low_cnt(fast_low_cnt),
    .hi_len(hi_len), .lo_len(lo_len));

  i2c_sclg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(line_hi));

  i2c_sclg_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .start_req(start_req),
    .stop_req(stop_req), .line_hi(line_hi), .hi_len(hi_len), .lo_len(lo_len),
    .scl_oe(scl_oe), .phase_tick(phase_tick), .idle(idle));

  // R1: idle never pulls the line
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !scl_oe);

endmodule

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;
  localparam int CW = 16;
  localparam int XTRA = 3;   // two sync stages plus detect cycle

  logic clk = 0, rst_n = 0, run_en = 0, start_req = 0, stop_req = 0, hold = 0;
  logic [1:0] spd_mode = 2'b01;
  logic [CW-1:0] sh = 0, sl = 0, fh = 0, fl = 0;
  logic scl_oe, phase_tick, idle, scl_line;

  always #4 clk = ~clk;   // 125 MHz
  assign scl_line = !scl_oe && !hold;

  i2c_scl_gen dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .spd_mode(spd_mode),
    .std_high_cnt(sh), .std_low_cnt(sl), .fast_high_cnt(fh), .fast_low_cnt(fl),
    .start_req(start_req), .stop_req(stop_req), .scl_in(scl_line),
    .scl_oe(scl_oe), .phase_tick(phase_tick), .idle(idle));

  int total = 0, bad = 0, tick_bad = 0;
  bit mon_on = 0, prev_oe = 0, run_val = 0;
  int run_len = 0;

  typedef struct { bit val; int len; string tag; } item_t;
  item_t sb[$];

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(bit v, int n, string tag);
    item_t it;
    it.val = v; it.len = n; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic close_run();
    item_t it;
    if (sb.size() == 0) check(0, "R7 unexpected phase", run_len, 0);
    else begin
      it = sb.pop_front();
      check(it.val == run_val, {it.tag, " phase level"}, run_val, it.val);
      check(it.len == run_len, {it.tag, " phase length"}, run_len, it.len);
    end
    run_len = 0;
  endtask

  // monitor: measures scl_oe runs while active; R10 tick relation
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase_tick !== (scl_oe != prev_oe)) tick_bad++;
      prev_oe = scl_oe;
      if (!mon_on) run_len = 0;
      else if (!idle) begin
        if (run_len > 0 && scl_oe != run_val) close_run();
        run_val = scl_oe;
        run_len++;
      end else if (run_len > 0) close_run();
    end
  end

  task automatic set_cfg(logic [1:0] sp, int a, int b, int c, int d);
    @(negedge clk);
    run_en = 0; spd_mode = sp; sh = CW'(a); sl = CW'(b); fh = CW'(c); fl = CW'(d);
    repeat (2) @(negedge clk);
    run_en = 1;
    @(negedge clk);
  endtask

  // driver: pushes expected phases and steers start/stop/hold
  task automatic burst(int nph, int hh, int ll, int str_ph, int s,
                       bit same, bit poke, string tag);
    for (int p = 0; p < nph; p++) begin
      push(1, ll, tag);
      push(0, hh + XTRA + ((p == str_ph) ? s : 0), tag);
    end
    mon_on = 1;
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    for (int p = 0; p < nph; p++) begin
      while (!scl_oe) @(negedge clk);
      if (p == str_ph) hold = 1;
      if (p == nph - 1 && !same) begin
        stop_req = 1; @(negedge clk); stop_req = 0;
      end
      while (scl_oe) @(negedge clk);
      if (p == str_ph) begin
        repeat (s) @(negedge clk);
        hold = 0;
      end
      if (p == 0 && poke) begin
        start_req = 1; @(negedge clk); start_req = 0;
      end
      if (p == nph - 1 && same) begin
        repeat (hh + XTRA - 1 - ((p == 0 && poke) ? 1 : 0)) @(negedge clk);
        stop_req = 1; @(negedge clk); stop_req = 0;
      end
    end
    while (!idle) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, {tag, " all phases seen"}, sb.size(), 0);
    check(idle && !scl_oe, "R7 idle and released after stop", {idle, scl_oe}, 2);
    sb.delete();
    mon_on = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(idle == 1, "R1 idle after reset", idle, 1);
    check(scl_oe == 0, "R1 scl_oe after reset", scl_oe, 0);
    check(phase_tick == 0, "R1 tick after reset", phase_tick, 0);

    // R11: start ignored while disabled
    start_req = 1; @(negedge clk); start_req = 0;
    repeat (4) @(negedge clk);
    check(idle && !scl_oe, "R11 start ignored when disabled", {idle, scl_oe}, 2);

    // R2 R3 R7 standard speed
    set_cfg(2'b01, 20, 24, 8, 12);
    burst(3, 20, 24, -1, 0, 0, 0, "R2 R3 std");
    // R4 fast code
    set_cfg(2'b10, 20, 24, 8, 12);
    burst(2, 8, 12, -1, 0, 0, 0, "R4 fast");
    // R4 code 11 behaves as standard
    set_cfg(2'b11, 20, 24, 8, 12);
    burst(1, 20, 24, -1, 0, 0, 0, "R4 code11");
    // R4 code 00 behaves as standard
    set_cfg(2'b00, 9, 10, 7, 7);
    burst(1, 9, 10, -1, 0, 0, 0, "R4 code00");
    // R5 clamp to 6
    set_cfg(2'b01, 2, 3, 8, 12);
    burst(2, 6, 6, -1, 0, 0, 0, "R5 clamp");
    // R6 stretch phase 1 by 7 cycles
    set_cfg(2'b10, 20, 24, 8, 12);
    burst(3, 8, 12, 1, 7, 0, 0, "R6 stretch");
    // R8 changes while enabled ignored
    set_cfg(2'b01, 10, 14, 8, 12);
    sh = 40; sl = 50; spd_mode = 2'b10; fh = 30; fl = 30;
    burst(2, 10, 14, -1, 0, 0, 0, "R8 frozen");
    // R11 stop while idle, start while running, both ignored
    set_cfg(2'b01, 10, 14, 8, 12);
    stop_req = 1; @(negedge clk); stop_req = 0;
    repeat (2) @(negedge clk);
    burst(2, 10, 14, -1, 0, 0, 1, "R11 ignored req");
    // R7 stop in the final high cycle
    burst(2, 10, 14, -1, 0, 1, 0, "R7 same cycle");
    burst(2, 10, 14, 1, 4, 1, 0, "R7 same cycle stretched");

    // R9 abort by enable drop
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    repeat (3) @(negedge clk);
    check(scl_oe == 1, "R9 running before abort", scl_oe, 1);
    run_en = 0;
    @(negedge clk);
    check(idle && !scl_oe, "R9 abort to idle", {idle, scl_oe}, 2);
    repeat (3) @(negedge clk);

    check(tick_bad == 0, "R10 tick matches scl_oe changes", tick_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule